// File: doc/BRIEF.md
# Panel Power Command Sequencer

This block brings a display panel's supply and backlight up or down. It walks a fixed table of register/data pairs and sends each pair as one two-byte write frame to a power-management device over an external serial shifter. A power-on request sends the enable table. After that the block waits, raises the display-enable output, and then waits again. A power-off request first drops display-enable and waits. Then it sends the disable table and waits once more.

The block presents each frame to the shifter on a level handshake. `spi_valid_o` stays high with the frame on `spi_frame_o` until the shifter pulses `spi_done_i`. `spi_err_i` qualifies that pulse. A failed frame is sent again, up to a fixed number of attempts. If the last attempt also fails, a sticky error flag is set and the block moves on to the next pair. A millisecond prescaler on the system clock times the delays. `busy_o` covers the whole sequence, from the accepted request to the end of the last delay.

Top module: `panel_pwr_seq`

## Requirements
- R1: While `spi_valid_o` is high, `spi_frame_o[15:8]` is the register number shifted left by one (bit 8 = 0) and `spi_frame_o[7:0]` is the data byte; frame and valid hold steady until a cycle with `spi_done_i` high.
- R2: A power-on sequence sends registers 54, 70, 71, 73, 74, 76, 77 in that order with data 0x5A, 0x27, 0x4F, 0xE1, 0xE1, 0xBF, 0xBF.
- R3: A power-off sequence sends registers 77, 76, 74, 73, 71, 70, 54 in that order with data 0x00, 0x00, 0x00, 0x00, 0x40, 0x20, 0x1A.
- R4: A frame completed with `spi_err_i` high is resent with the same content, up to MAX_TRIES (default 4) attempts in total. If the last attempt fails, `err_o` is set and the block continues with the next pair.
- R5: `err_o` stays set while the block is idle and is cleared when the next request is accepted.
- R6: The table ends at an entry whose register number is zero, so no frame is issued beyond the seven pairs.
- R7: At power-on, `disp_en_o` rises D+1 cycles after the clock edge that completes the last frame, and `busy_o` falls D cycles after that (D = DELAY_MS × CLK_PER_MS).
- R8: At power-off, `disp_en_o` falls in the cycle after acceptance, the first frame appears D cycles later, and `busy_o` falls D+1 cycles after the last frame completes.
- R9: Requests that arrive while `busy_o` is high are ignored.
- R10: If both requests are high together while the block is idle, power-on wins.
- R11: After reset, `busy_o`, `spi_valid_o`, `disp_en_o` and `err_o` are low.
- R12: `busy_o` is high from the cycle after acceptance until the final delay ends, and `spi_valid_o` is high only while `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| on_req_i | input | 1 | Power-on request |
| off_req_i | input | 1 | Power-off request |
| spi_done_i | input | 1 | One-cycle pulse: shifter has finished the presented frame |
| spi_err_i | input | 1 | Frame failed, valid with spi_done_i |
| spi_valid_o | output | 1 | Frame presented to the shifter |
| spi_frame_o | output | 16 | Shifted register number (high byte) and data (low byte) |
| disp_en_o | output | 1 | Display-enable output |
| busy_o | output | 1 | Sequence in progress |
| err_o | output | 1 | Sticky flag: a pair failed on every attempt |

## Verification
The assertions assume that `spi_done_i` is a single-cycle pulse and arrives only while `spi_valid_o` is high. They also assume that `spi_err_i` means something only in that same cycle. The bench's shifter model follows these rules. It responds a fixed two cycles after it first sees a frame, drops done on the next cycle, and never answers while the block is idle. Errors are injected per pair and per attempt from the vector table, so retries never go past what the model can account for.

// File: rtl/pps_pkg.sv
package pps_pkg;
  localparam int unsigned IDX_W = 3;
  localparam int unsigned REG_W = 7;

  typedef enum logic [2:0] {
    PH_IDLE, PH_PRE, PH_XFER, PH_MID, PH_POST
  } phase_e;

  // {register, data}; register 0 ends the table
  function automatic logic [REG_W+7:0] up_entry(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return {7'd54, 8'h5A};
      3'd1:    return {7'd70, 8'h27};
      3'd2:    return {7'd71, 8'h4F};
      3'd3:    return {7'd73, 8'hE1};
      3'd4:    return {7'd74, 8'hE1};
      3'd5:    return {7'd76, 8'hBF};
      3'd6:    return {7'd77, 8'hBF};
      default: return '0;
    endcase
  endfunction

  function automatic logic [REG_W+7:0] dn_entry(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return {7'd77, 8'h00};
      3'd1:    return {7'd76, 8'h00};
      3'd2:    return {7'd74, 8'h00};
      3'd3:    return {7'd73, 8'h00};
      3'd4:    return {7'd71, 8'h40};
      3'd5:    return {7'd70, 8'h20};
      3'd6:    return {7'd54, 8'h1A};
      default: return '0;
    endcase
  endfunction
endpackage

// File: rtl/pps_cmd_rom.sv
module pps_cmd_rom
  import pps_pkg::*;
(
  input  logic             up_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [REG_W-1:0] reg_o,
  output logic [7:0]       dat_o,
  output logic             last_o
);
  logic [REG_W+7:0] entry;

  always_comb begin
    entry  = up_i ? up_entry(idx_i) : dn_entry(idx_i);
    reg_o  = entry[REG_W+7:8];
    dat_o  = entry[7:0];
    last_o = (entry[REG_W+7:8] == '0);
  end
endmodule

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
  parameter int unsigned CLK_PER_MS = 125000,
  parameter int unsigned DELAY_MS   = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic done_o
);
  localparam int unsigned PW = $clog2(CLK_PER_MS + 1);
  localparam int unsigned MW = $clog2(DELAY_MS + 1);
  localparam logic [PW-1:0] P_LAST = PW'(CLK_PER_MS - 1);
  localparam logic [MW-1:0] M_LAST = MW'(DELAY_MS - 1);

  logic          run_q;
  logic [PW-1:0] presc_q;
  logic [MW-1:0] ms_q;
  logic          tick;

  assign tick   = run_q && (presc_q == P_LAST);
  assign done_o = tick && (ms_q == M_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      presc_q <= '0;
      ms_q    <= '0;
    end else if (start_i) begin
      run_q   <= 1'b1;
      presc_q <= '0;
      ms_q    <= '0;
    end else if (run_q) begin
      if (tick) begin
        presc_q <= '0;
        if (done_o) run_q <= 1'b0;
        else        ms_q  <= ms_q + 1'b1;
      end else begin
        presc_q <= presc_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/pps_retry_ctr.sv
module pps_retry_ctr #(
  parameter int unsigned MAX_TRIES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic fail_i,
  output logic final_o
);
  localparam int unsigned TW = (MAX_TRIES > 1) ? $clog2(MAX_TRIES) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(MAX_TRIES - 1);

  logic [TW-1:0] tries_q;

  assign final_o = (tries_q == T_LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                tries_q <= '0;
    else if (clear_i)           tries_q <= '0;
    else if (fail_i && !final_o) tries_q <= tries_q + 1'b1;
  end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
  import pps_pkg::*;
#(
  parameter int unsigned CLK_PER_MS = 125000,
  parameter int unsigned DELAY_MS   = 10,
  parameter int unsigned MAX_TRIES  = 4
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        on_req_i,
  input  logic        off_req_i,
  input  logic        spi_done_i,
  input  logic        spi_err_i,
  output logic        spi_valid_o,
  output logic [15:0] spi_frame_o,
  output logic        disp_en_o,
  output logic        busy_o,
  output logic        err_o
);
  phase_e           phase_q;
  logic             up_q;
  logic [IDX_W-1:0] idx_q;
  logic             disp_q;
  logic             err_q;

  logic [REG_W-1:0] rom_reg;
  logic [7:0]       rom_dat;
  logic             rom_last;
  logic             tmr_start;
  logic             tmr_done;
  logic             accept_up;
  logic             accept_dn;
  logic             xfer_ret;
  logic             retry_fail;
  logic             retry_final;
  logic             retry_clear;

  pps_cmd_rom i_rom (
    .up_i   (up_q),
    .idx_i  (idx_q),
    .reg_o  (rom_reg),
    .dat_o  (rom_dat),
    .last_o (rom_last)
  );

  pps_ms_timer #(
    .CLK_PER_MS (CLK_PER_MS),
    .DELAY_MS   (DELAY_MS)
  ) i_tmr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (tmr_start),
    .done_o  (tmr_done)
  );

  pps_retry_ctr #(
    .MAX_TRIES (MAX_TRIES)
  ) i_retry (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (retry_clear),
    .fail_i  (retry_fail),
    .final_o (retry_final)
  );

  always_comb begin
    accept_up   = (phase_q == PH_IDLE) && on_req_i;
    accept_dn   = (phase_q == PH_IDLE) && !on_req_i && off_req_i;
    xfer_ret    = (phase_q == PH_XFER) && !rom_last && spi_done_i;
    retry_fail  = xfer_ret && spi_err_i;
    retry_clear = accept_up || accept_dn || (xfer_ret && (!spi_err_i || retry_final));
    tmr_start   = accept_dn
               || ((phase_q == PH_XFER) && rom_last)
               || ((phase_q == PH_MID) && tmr_done);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q <= PH_IDLE;
      up_q    <= 1'b0;
      idx_q   <= '0;
      disp_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      case (phase_q)
        PH_IDLE: begin
          if (accept_up) begin
            up_q    <= 1'b1;
            idx_q   <= '0;
            err_q   <= 1'b0;
            phase_q <= PH_XFER;
          end else if (accept_dn) begin
            up_q    <= 1'b0;
            idx_q   <= '0;
            err_q   <= 1'b0;
            disp_q  <= 1'b0;
            phase_q <= PH_PRE;
          end
        end
        PH_PRE: if (tmr_done) phase_q <= PH_XFER;
        PH_XFER: begin
          if (rom_last) begin
            phase_q <= up_q ? PH_MID : PH_POST;
          end else if (xfer_ret && (!spi_err_i || retry_final)) begin
            if (spi_err_i) err_q <= 1'b1;
            idx_q <= idx_q + 1'b1;
          end
        end
        PH_MID: begin
          if (tmr_done) begin
            disp_q  <= 1'b1;
            phase_q <= PH_POST;
          end
        end
        PH_POST: if (tmr_done) phase_q <= PH_IDLE;
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

  assign spi_valid_o = (phase_q == PH_XFER) && !rom_last;
  assign spi_frame_o = {rom_reg, 1'b0, rom_dat};
  assign disp_en_o   = disp_q;
  assign busy_o      = (phase_q != PH_IDLE);
  assign err_o       = err_q;
endmodule

// File: rtl/pps_checker.sv
module pps_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        spi_done_i,
  input logic        spi_err_i,
  input logic        spi_valid_o,
  input logic [15:0] spi_frame_o,
  input logic        disp_en_o,
  input logic        busy_o,
  input logic        err_o
);
  assert_frame_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_valid_o && !spi_done_i |=> spi_valid_o && $stable(spi_frame_o));

  assert_reg_shift_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_valid_o |-> !spi_frame_o[8]);

  assert_err_source_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $past(spi_done_i && spi_err_i));

  assert_valid_busy_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    spi_valid_o |-> busy_o);

  assert_idle_clean_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> !spi_valid_o);

  assert_disp_in_seq_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(disp_en_o) |-> busy_o);
endmodule

bind panel_pwr_seq pps_checker i_pps_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .spi_done_i  (spi_done_i),
  .spi_err_i   (spi_err_i),
  .spi_valid_o (spi_valid_o),
  .spi_frame_o (spi_frame_o),
  .disp_en_o   (disp_en_o),
  .busy_o      (busy_o),
  .err_o       (err_o)
);

// File: tb/test_panel_pwr_seq.sv
`timescale 1ns/1ps
module test_panel_pwr_seq;
  localparam int CPM = 8;
  localparam int DMS = 10;
  localparam int D   = CPM * DMS;

  // {up, fail_idx[2:0], fail_n[2:0], exp_err, exp_frames[4:0]}
  localparam int NV = 6;
  localparam logic [12:0] VEC [NV] = '{
    {1'b1, 3'd0, 3'd0, 1'b0, 5'd7},
    {1'b0, 3'd0, 3'd0, 1'b0, 5'd7},
    {1'b1, 3'd2, 3'd3, 1'b0, 5'd10},
    {1'b0, 3'd0, 3'd4, 1'b1, 5'd10},
    {1'b1, 3'd6, 3'd5, 1'b1, 5'd10},
    {1'b0, 3'd3, 3'd1, 1'b0, 5'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic on_req = 1'b0, off_req = 1'b0;
  logic spi_done = 1'b0, spi_err = 1'b0;
  logic spi_valid, disp_en, busy, err;
  logic [15:0] spi_frame;

  int n_chk = 0, n_err = 0;
  int cyc = 0;

  // shifter model state
  bit  exp_up = 1'b0;
  int  f_idx = 7, f_n = 0;
  int  p = 0, a = 0, nfr = 0;
  logic rb_prev = 1'b0;

  // timing monitor
  int t_first_v, t_last_vfall, t_disp, t_bfall;
  bit got_v;
  logic pv = 1'b0, pd = 1'b0, pb = 1'b0;

  always #4 clk = ~clk;

  panel_pwr_seq #(.CLK_PER_MS(CPM), .DELAY_MS(DMS)) i_panel_pwr_seq (
    .clk_i(clk), .rst_ni(rst_n), .on_req_i(on_req), .off_req_i(off_req),
    .spi_done_i(spi_done), .spi_err_i(spi_err), .spi_valid_o(spi_valid),
    .spi_frame_o(spi_frame), .disp_en_o(disp_en), .busy_o(busy), .err_o(err));

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
    end
  endtask

  function automatic int tb_reg(input bit up, input int i);
    int ur[7] = '{54, 70, 71, 73, 74, 76, 77};
    int dr[7] = '{77, 76, 74, 73, 71, 70, 54};
    return up ? ur[i] : dr[i];
  endfunction

  function automatic int tb_dat(input bit up, input int i);
    int ud[7] = '{'h5A, 'h27, 'h4F, 'hE1, 'hE1, 'hBF, 'hBF};
    int dd[7] = '{'h00, 'h00, 'h00, 'h00, 'h40, 'h20, 'h1A};
    return up ? ud[i] : dd[i];
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // shifter model: answer two cycles after a frame is seen
  initial begin
    forever begin
      @(negedge clk);
      spi_done = 1'b0;
      spi_err  = 1'b0;
      if (busy && !rb_prev) begin p = 0; a = 0; nfr = 0; end
      rb_prev = busy;
      if (spi_valid) begin
        bit e;
        nfr++;
        if (p > 6) begin
          chk(1'b0, "R6", p, 6);
        end else begin
          int ef;
          ef = ((tb_reg(exp_up, p) << 9) | tb_dat(exp_up, p));
          chk(spi_frame == 16'(ef), exp_up ? "R1 R2" : "R1 R3", spi_frame, ef);
        end
        e = (p == f_idx) && (a < f_n);
        @(negedge clk);
        chk(spi_valid && spi_frame[8] == 1'b0, "R1", spi_valid, 1);
        @(negedge clk);
        rb_prev  = busy;
        spi_done = 1'b1;
        spi_err  = e;
        if (e && a < 3) a++;
        else begin p++; a = 0; end
      end
    end
  end

  always @(negedge clk) begin
    if (busy && !pb) begin
      got_v = 1'b0; t_first_v = -1; t_last_vfall = -1; t_disp = -1; t_bfall = -1;
    end
    if (spi_valid && !pv && !got_v) begin got_v = 1'b1; t_first_v = cyc; end
    if (!spi_valid && pv) t_last_vfall = cyc;
    if (disp_en != pd) t_disp = cyc;
    if (!busy && pb) t_bfall = cyc;
    pv = spi_valid; pd = disp_en; pb = busy;
  end

  task automatic request(input bit up, input bit both);
    @(negedge clk);
    on_req  = up | both;
    off_req = !up | both;
    @(negedge clk);
    on_req  = 1'b0;
    off_req = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !spi_valid && !disp_en && !err, "R11",
        {busy, spi_valid, disp_en, err}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !spi_valid && !disp_en && !err, "R11",
        {busy, spi_valid, disp_en, err}, 0);

    for (int v = 0; v < NV; v++) begin
      exp_up = VEC[v][12];
      f_idx  = int'(VEC[v][11:9]);
      f_n    = int'(VEC[v][8:6]);
      request(exp_up, 1'b0);
      chk(busy, "R12", busy, 1);
      chk(!err, "R5", err, 0);
      wait_idle();
      chk(nfr == int'(VEC[v][4:0]), "R4 R6", nfr, VEC[v][4:0]);
      chk(err == VEC[v][5], "R4", err, VEC[v][5]);
      chk(disp_en == exp_up, exp_up ? "R7" : "R8", disp_en, exp_up);
      if (exp_up) begin
        chk(t_disp - t_last_vfall == D + 1, "R7", t_disp - t_last_vfall, D + 1);
        chk(t_bfall - t_disp == D, "R7", t_bfall - t_disp, D);
      end else begin
        chk(t_first_v - t_disp == D, "R8", t_first_v - t_disp, D);
        chk(t_bfall - t_last_vfall == D + 1, "R8", t_bfall - t_last_vfall, D + 1);
      end
      repeat (5) @(negedge clk);
      chk(err == VEC[v][5], "R5", err, VEC[v][5]);
    end

    // R9: requests while busy are ignored (power-off running, display stays low)
    exp_up = 1'b1; f_idx = 7; f_n = 0;
    request(1'b1, 1'b0);
    wait_idle();
    exp_up = 1'b0;
    request(1'b0, 1'b0);
    repeat (D + 6) @(negedge clk);
    on_req = 1'b1;
    @(negedge clk);
    on_req = 1'b0;
    repeat (3) @(negedge clk);
    off_req = 1'b1;
    @(negedge clk);
    off_req = 1'b0;
    wait_idle();
    chk(nfr == 7, "R9", nfr, 7);
    chk(!disp_en, "R9", disp_en, 0);
    repeat (4) @(negedge clk);
    chk(!busy, "R9", busy, 0);

    // R10: both requests together, power-on wins
    exp_up = 1'b1;
    request(1'b1, 1'b1);
    chk(spi_valid && spi_frame[15:9] == 7'd54, "R10", spi_frame[15:9], 54);
    wait_idle();
    chk(disp_en && nfr == 7, "R10", {disp_en, 5'(nfr)}, {1'b1, 5'd7});

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule